// File: doc/BRIEF.md
# Byte Rotate and Shift Unit with Condition Flags

This block takes one byte operand and an incoming carry bit, applies one of seven rotate or shift operations chosen by a 3-bit operation code, and returns the shifted byte with four condition flags: zero, subtract, half-carry and carry. The caller fetches the operand from a register or a memory byte. It writes the result back to the same place and stores the flags in its flag register. Operand addressing and instruction decode stay with the caller.

The rotates come in two kinds. The through-carry rotates feed the incoming carry into the vacated bit. The circular rotates feed in the bit that leaves the other end. A separate accumulator-short input selects the compact accumulator form of an operation, in which the zero flag is always cleared. The computation itself is combinational. A valid strobe loads the result and flags into an output register, so an answer appears one clock after the operation is presented, which is one machine cycle.

Top module: `rsu_top`

## Requirements
- R1: When `inValid` is high at a rising clock edge, `result` and the four flags take the values for that cycle's inputs right after the edge, and `outValid` is high for exactly the cycle that follows each strobed edge.
- R2: When `inValid` is low at an edge, `result` and all flags keep their previous values, whatever the other inputs do.
- R3: Code 0 (rotate left through carry): result is {x[6:0], carryIn}, carry is x[7].
- R4: Code 1 (rotate right through carry): result is {carryIn, x[7:1]}, carry is x[0].
- R5: Code 2 (rotate left circular): result is {x[6:0], x[7]}, carry is x[7].
- R6: Code 3 (rotate right circular): result is {x[0], x[7:1]}, carry is x[0].
- R7: Code 4 (arithmetic shift left): result is {x[6:0], 0}, carry is x[7].
- R8: Code 5 (arithmetic shift right): result is {x[7], x[7:1]}, so bit 7 is kept, and carry is x[0].
- R9: Code 6 (logical shift right): result is {0, x[7:1]}, carry is x[0].
- R10: Code 7 passes the operand through unchanged and copies `carryIn` to the carry flag.
- R11: Every loaded operation clears the subtract and half-carry flags.
- R12: With `accShort` low, the zero flag is set exactly when the 8-bit result is zero. With `accShort` high, the zero flag is cleared even when the result is zero.
- R13: During reset, `outValid`, `result` and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Loads this cycle's operation into the output register |
| opSel | input | 3 | Operation code, 0 to 7 |
| accShort | input | 1 | Accumulator-short form; forces the zero flag clear |
| operand | input | 8 | Byte to rotate or shift |
| carryIn | input | 1 | Current carry flag of the caller |
| outValid | output | 1 | High in the cycle after a strobe |
| result | output | 8 | Rotated or shifted byte for write-back |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Subtract flag |
| flagH | output | 1 | Half-carry flag |
| flagC | output | 1 | Carry flag |

## Verification
A wrong fill-source or direction decode in the control shows up in the very next cycle. The bit at one end of `result` is wrong, or `flagC` takes the wrong edge bit, for only the affected operation codes. Because of this, random operands are spread over all eight codes, with both carry-in values and both forms. A load strobe that fires when it should not shows up as a changed output while `inValid` is low. A stuck zero-flag path is exposed by directed zero-result cases in both forms, such as shifting 0x01 right or 0x80 left.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [1:0] {
    FILL_ZERO,
    FILL_CARRY,
    FILL_WRAP,
    FILL_SIGN
  } fill_e;

  typedef struct packed {
    logic  load;
    logic  dirLeft;
    fill_e fillSrc;
    logic  passThrough;
    logic  clearZ;
  } strobe_t;
endpackage

// File: rtl/rsu_ctrl.sv
module rsu_ctrl
  import rsu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] opSel,
  input  logic            accShort,
  output strobe_t         ctl,
  output logic            outValid
);
  always_comb begin
    ctl             = '0;
    ctl.load        = inValid;
    ctl.clearZ      = accShort;
    ctl.fillSrc     = FILL_ZERO;
    case (opSel)
      3'd0: begin ctl.dirLeft = 1'b1; ctl.fillSrc = FILL_CARRY; end
      3'd1: begin ctl.dirLeft = 1'b0; ctl.fillSrc = FILL_CARRY; end
      3'd2: begin ctl.dirLeft = 1'b1; ctl.fillSrc = FILL_WRAP;  end
      3'd3: begin ctl.dirLeft = 1'b0; ctl.fillSrc = FILL_WRAP;  end
      3'd4: begin ctl.dirLeft = 1'b1; ctl.fillSrc = FILL_ZERO;  end
      3'd5: begin ctl.dirLeft = 1'b0; ctl.fillSrc = FILL_SIGN;  end
      3'd6: begin ctl.dirLeft = 1'b0; ctl.fillSrc = FILL_ZERO;  end
      default: ctl.passThrough = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid) |-> outValid); // R1
endmodule

// File: rtl/rsu_dpath.sv
module rsu_dpath
  import rsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagH,
  output logic              flagC
);
  localparam int MSB = DATA_W - 1;

  logic              fillBit;
  logic              edgeBit;
  logic [DATA_W-1:0] nextRes;
  logic              nextC;
  logic              nextZ;

  always_comb begin
    edgeBit = ctl.dirLeft ? operand[MSB] : operand[0];
    case (ctl.fillSrc)
      FILL_CARRY: fillBit = carryIn;
      FILL_WRAP:  fillBit = edgeBit;
      FILL_SIGN:  fillBit = operand[MSB];
      default:    fillBit = 1'b0;
    endcase
    if (ctl.passThrough) begin
      nextRes = operand;
      nextC   = carryIn;
    end else if (ctl.dirLeft) begin
      nextRes = {operand[MSB-1:0], fillBit};
      nextC   = edgeBit;
    end else begin
      nextRes = {fillBit, operand[MSB:1]};
      nextC   = edgeBit;
    end
    nextZ = !ctl.clearZ && (nextRes == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flagZ  <= 1'b0;
      flagN  <= 1'b0;
      flagH  <= 1'b0;
      flagC  <= 1'b0;
    end else if (ctl.load) begin
      result <= nextRes;
      flagZ  <= nextZ;
      flagN  <= 1'b0;
      flagH  <= 1'b0;
      flagC  <= nextC;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.load) |-> $stable(result) && $stable(flagC)); // R2
  AST_SHORT_ZCLR: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.load && ctl.clearZ) |-> !flagZ); // R12
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.load && !ctl.clearZ) |-> (flagZ == (result == '0))); // R12
  AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.load && !ctl.passThrough && ctl.fillSrc == FILL_SIGN)
      |-> result[MSB] == $past(operand[MSB])); // R8
endmodule

// File: rtl/rsu_top.sv
module rsu_top
  import rsu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opSel,
  input  logic              accShort,
  input  logic [DATA_W-1:0] operand,
  input  logic              carryIn,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              flagZ,
  output logic              flagN,
  output logic              flagH,
  output logic              flagC
);
  strobe_t ctl;

  rsu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .accShort(accShort), .ctl(ctl), .outValid(outValid)
  );

  rsu_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand), .carryIn(carryIn),
    .result(result), .flagZ(flagZ), .flagN(flagN), .flagH(flagH), .flagC(flagC)
  );
endmodule

// File: tb/tb_rsu_top.sv
module tb_rsu_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [2:0] opSel = '0;
  logic       accShort = 1'b0;
  logic [7:0] operand = '0;
  logic       carryIn = 1'b0;
  logic       outValid, flagZ, flagN, flagH, flagC;
  logic [7:0] result;

  int runCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rsu_top dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .accShort(accShort), .operand(operand), .carryIn(carryIn),
    .outValid(outValid), .result(result), .flagZ(flagZ), .flagN(flagN),
    .flagH(flagH), .flagC(flagC)
  );

  // expected {result, Z, N, H, C}
  function automatic logic [11:0] model(input logic [2:0] op, input logic sh,
                                        input logic [7:0] x, input logic c);
    logic [7:0] r;
    logic co;
    case (op)
      3'd0: begin r = {x[6:0], c};    co = x[7]; end // R3
      3'd1: begin r = {c, x[7:1]};    co = x[0]; end // R4
      3'd2: begin r = {x[6:0], x[7]}; co = x[7]; end // R5
      3'd3: begin r = {x[0], x[7:1]}; co = x[0]; end // R6
      3'd4: begin r = {x[6:0], 1'b0}; co = x[7]; end // R7
      3'd5: begin r = {x[7], x[7:1]}; co = x[0]; end // R8
      3'd6: begin r = {1'b0, x[7:1]}; co = x[0]; end // R9
      default: begin r = x;           co = c;    end // R10
    endcase
    return {r, (!sh && r == 8'h00), 1'b0, 1'b0, co}; // R11 R12
  endfunction

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3"; 3'd1: return "R4"; 3'd2: return "R5";
      3'd3: return "R6"; 3'd4: return "R7"; 3'd5: return "R8";
      3'd6: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [2:0] op, input logic sh,
                       input logic [7:0] x, input logic c, input string tag);
    @(negedge clk);
    inValid = 1'b1; opSel = op; accShort = sh; operand = x; carryIn = c;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " R1 R11 R12"}, {result, flagZ, flagN, flagH, flagC}, model(op, sh, x, c));
    check("R1 valid", {11'd0, outValid}, 12'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runCount, failCount);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [11:0] held;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13", {result, flagZ, flagN, flagH, flagC, outValid}, 13'd0);
    rstN = 1'b1;

    // directed corners
    runOp(3'd0, 1'b0, 8'h80, 1'b0, "R3");   // zero result, carry out
    runOp(3'd0, 1'b0, 8'h80, 1'b1, "R3");
    runOp(3'd1, 1'b0, 8'h01, 1'b0, "R4");
    runOp(3'd2, 1'b0, 8'h81, 1'b0, "R5");
    runOp(3'd3, 1'b0, 8'h01, 1'b1, "R6");
    runOp(3'd4, 1'b0, 8'h80, 1'b1, "R7");
    runOp(3'd5, 1'b0, 8'h81, 1'b0, "R8");
    runOp(3'd5, 1'b0, 8'h01, 1'b1, "R8");
    runOp(3'd6, 1'b0, 8'hff, 1'b0, "R9");
    runOp(3'd6, 1'b0, 8'h01, 1'b0, "R9");
    runOp(3'd7, 1'b0, 8'h00, 1'b1, "R10");
    runOp(3'd7, 1'b1, 8'h5a, 1'b0, "R10");
    runOp(3'd4, 1'b1, 8'h80, 1'b0, "R12 short"); // zero result, Z still clear
    runOp(3'd1, 1'b1, 8'h01, 1'b0, "R12 short");

    // R2 hold while idle
    runOp(3'd2, 1'b0, 8'h3c, 1'b1, "R5");
    held = {result, flagZ, flagN, flagH, flagC};
    @(negedge clk);
    opSel = 3'd4; operand = 8'hff; carryIn = 1'b1; accShort = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R2", {result, flagZ, flagN, flagH, flagC}, held);
    check("R1 idle valid", {11'd0, outValid}, 12'd0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      logic [7:0] x;
      op = 3'($urandom_range(0, 7));
      x  = (i % 8 == 0) ? 8'h00 : 8'($urandom);
      runOp(op, 1'($urandom), x, 1'($urandom), reqOf(op));
    end

    // back-to-back strobes
    @(negedge clk);
    inValid = 1'b1; opSel = 3'd0; accShort = 1'b0; operand = 8'h55; carryIn = 1'b1;
    @(negedge clk);
    check("R1 b2b first R3", {result, flagZ, flagN, flagH, flagC}, model(3'd0, 1'b0, 8'h55, 1'b1));
    opSel = 3'd6; operand = 8'h02; carryIn = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R1 b2b second R9", {result, flagZ, flagN, flagH, flagC}, model(3'd6, 1'b0, 8'h02, 1'b0));
    check("R1 b2b valid", {11'd0, outValid}, 12'd1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule